// File: doc/BRIEF.md
# Tagged Receive Queue with Overrun Guard

This block buffers the bytes that a serial receiver's CRC and address stage has accepted. Next to each data byte it stores two tag bits: one marks the last byte of a frame, and one marks a byte that closed a frame whose checksum failed. The consumer side works as a show-ahead pop port. The head entry is always presented while the queue holds data, and a pop request removes it.

Two service requests leave the block. The interrupt request rises when the fill level reaches a selectable threshold, if the interrupt is enabled. The DMA request rises at the same threshold, but only while no stored entry carries a checksum-error tag. Software has to handle such entries by hand. Once those entries have been popped, the DMA request can come back.

A write that arrives while the queue is full is discarded. The stored contents are left as they were, and a sticky overrun flag is set. A software write-one-to-clear pulse clears the flag. The clear input is pulsed when the receiver is switched off, and it empties the whole queue.

Top module: `tagq_rx_fifo`

## Requirements
- R1: After reset the queue is empty: level is 0, and rd_valid, full, irq, dma_req and overrun are all low.
- R2: Entries leave in the order they were written. rd_data, rd_eof and rd_crc_err show the oldest stored entry, with its tags unchanged, whenever rd_valid is high. rd_valid is high exactly when level is non-zero.
- R3: A write while level equals DEPTH is dropped and the stored entries are unchanged. A pop in the same cycle still removes the head.
- R4: A dropped write sets overrun on the next edge. overrun stays high until an ovr_clr pulse. If a dropped write and ovr_clr fall in the same cycle, overrun stays set.
- R5: trig_sel chooses the threshold: 2'b00 gives 8 entries, 2'b01 gives 16, and 2'b10 or 2'b11 gives 32.
- R6: irq is high exactly when irq_en is high and level is at or above the threshold.
- R7: dma_req is high exactly when level is at or above the threshold and no stored entry has its checksum-error tag set. It returns once all such entries have been popped.
- R8: A clear pulse empties the queue and lowers overrun at the next edge. It takes priority over any write or pop in the same cycle.
- R9: A pop while the queue is empty has no effect. level stays 0, with no underflow.
- R10: level always equals the number of stored entries and never exceeds DEPTH. full is high exactly at DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Synchronous flush, pulsed on receiver disable |
| wr_en | input | 1 | Write strobe from the CRC/address stage |
| wr_data | input | DW | Byte to store |
| wr_eof | input | 1 | End-of-frame tag for this byte |
| wr_crc_err | input | 1 | Checksum-error tag for this byte |
| rd_en | input | 1 | Pop the head entry |
| rd_valid | output | 1 | Head entry is present |
| rd_data | output | DW | Head byte |
| rd_eof | output | 1 | Head end-of-frame tag |
| rd_crc_err | output | 1 | Head checksum-error tag |
| trig_sel | input | 2 | Threshold select |
| irq_en | input | 1 | Interrupt request enable |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA service request |
| overrun | output | 1 | Sticky dropped-write flag |
| ovr_clr | input | 1 | Write-one-to-clear for overrun |
| full | output | 1 | Queue holds DEPTH entries |
| level | output | $clog2(DEPTH+1) | Number of stored entries |

## Verification
The properties assume that rst_n is held low across the first edges, and that every control input is a plain level that is stable at the clock edge. They also assume that trig_sel stays within its two bits and that DEPTH is at least the largest threshold, 32. The stimulus drives all inputs on the falling edge from one task. A bench model tracks the queue contents, the overrun flag and the threshold rule. Random phases alternate between write-heavy and pop-heavy traffic so that the queue reaches full and empty many times. Directed steps cover the overflow, set-versus-clear, checksum-tag and flush corners.

// File: rtl/tagq_pkg.sv
package tagq_pkg;

  localparam int unsigned TRIG_MAX = 32;

  typedef enum logic [1:0] {
    TRIG_LO  = 2'b00,
    TRIG_MID = 2'b01,
    TRIG_HI  = 2'b10,
    TRIG_HI2 = 2'b11
  } tagq_trig_e;

  // Threshold in entries for a select code.
  function automatic int unsigned trig_count(input logic [1:0] sel);
    case (tagq_trig_e'(sel))
      TRIG_LO:  return 8;
      TRIG_MID: return 16;
      default:  return TRIG_MAX;
    endcase
  endfunction

  // Occupancy after one cycle of optional increment and decrement.
  function automatic int unsigned level_after(input int unsigned cur,
                                              input logic inc,
                                              input logic dec);
    int unsigned n;
    n = cur;
    if (inc && !dec) n = cur + 1;
    if (dec && !inc) n = cur - 1;
    return n;
  endfunction

  // Index of the next slot in a ring of the given depth.
  function automatic int unsigned ring_next(input int unsigned idx,
                                            input int unsigned depth);
    return (idx == depth - 1) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/tagq_ram.sv
module tagq_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int EW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/tagq_ctrl.sv
module tagq_ctrl
  import tagq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic          wr_err,
  input  logic          rd_en,
  input  logic          head_err,
  input  logic          ovr_clr,
  output logic          push,
  output logic          pop,
  output logic          drop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_cnt,
  output logic          overrun,
  output logic          is_full,
  output logic          is_empty
);

  logic push_err, pop_err;

  always_comb begin
    is_empty = (count == '0);
    is_full  = (32'(count) == DEPTH);
    push     = wr_en && !is_full && !clear;
    drop     = wr_en &&  is_full && !clear;
    pop      = rd_en && !is_empty && !clear;
    push_err = push && wr_err;
    pop_err  = pop && head_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
      overrun <= 1'b0;
    end else if (clear) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
      overrun <= 1'b0;
    end else begin
      if (push) wr_ptr <= AW'(ring_next(32'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= AW'(ring_next(32'(rd_ptr), DEPTH));
      count   <= CW'(level_after(32'(count), push, pop));
      err_cnt <= CW'(level_after(32'(err_cnt), push_err, pop_err));
      if (drop)         overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
    end
  end

endmodule

// File: rtl/tagq_req.sv
module tagq_req
  import tagq_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] err_cnt,
  input  logic [1:0]    trig_sel,
  input  logic          irq_en,
  output logic          at_trig,
  output logic          irq,
  output logic          dma_req
);

  always_comb begin
    at_trig = (32'(count) >= trig_count(trig_sel));
    irq     = irq_en && at_trig;
    dma_req = at_trig && (err_cnt == '0);
  end

endmodule

// File: rtl/tagq_rx_fifo.sv
module tagq_rx_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       wr_en,
  input  logic [DW-1:0]              wr_data,
  input  logic                       wr_eof,
  input  logic                       wr_crc_err,
  input  logic                       rd_en,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  output logic                       rd_eof,
  output logic                       rd_crc_err,
  input  logic [1:0]                 trig_sel,
  input  logic                       irq_en,
  output logic                       irq,
  output logic                       dma_req,
  output logic                       overrun,
  input  logic                       ovr_clr,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 2;

  logic          push, pop, drop, at_trig, empty;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] err_cnt;
  logic [EW-1:0] head;

  tagq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .wr_en    (wr_en),
    .wr_err   (wr_crc_err),
    .rd_en    (rd_en),
    .head_err (head[EW-1]),
    .ovr_clr  (ovr_clr),
    .push     (push),
    .pop      (pop),
    .drop     (drop),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .count    (level),
    .err_cnt  (err_cnt),
    .overrun  (overrun),
    .is_full  (full),
    .is_empty (empty)
  );

  tagq_ram #(.DEPTH(DEPTH), .AW(AW), .EW(EW)) u_ram (
    .clk   (clk),
    .we    (push),
    .waddr (wr_ptr),
    .wdata ({wr_crc_err, wr_eof, wr_data}),
    .raddr (rd_ptr),
    .rdata (head)
  );

  tagq_req #(.CW(CW)) u_req (
    .count    (level),
    .err_cnt  (err_cnt),
    .trig_sel (trig_sel),
    .irq_en   (irq_en),
    .at_trig  (at_trig),
    .irq      (irq),
    .dma_req  (dma_req)
  );

  assign rd_valid   = !empty;
  assign rd_data    = head[DW-1:0];
  assign rd_eof     = head[DW];
  assign rd_crc_err = head[DW+1];

endmodule

// File: rtl/tagq_rx_fifo_chk.sv
module tagq_rx_fifo_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ovr_clr,
  input logic          irq_en,
  input logic          full,
  input logic [CW-1:0] level,
  input logic          overrun,
  input logic          irq,
  input logic          dma_req,
  input logic [CW-1:0] err_cnt,
  input logic          rd_valid,
  input logic          drop,
  input logic          at_trig
);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH); // R10
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !clear) |=> (level == $past(level))); // R3
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> overrun); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr && !clear) |=> overrun); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en || !at_trig) |-> !irq); // R6
  AST_DMA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt != '0) |-> !dma_req); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (level == '0 && !overrun && !rd_valid)); // R8
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_valid && rd_en && !wr_en && !clear) |=> (level == '0)); // R9

endmodule

bind tagq_rx_fifo tagq_rx_fifo_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clear    (clear),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .ovr_clr  (ovr_clr),
  .irq_en   (irq_en),
  .full     (full),
  .level    (level),
  .overrun  (overrun),
  .irq      (irq),
  .dma_req  (dma_req),
  .err_cnt  (err_cnt),
  .rd_valid (rd_valid),
  .drop     (drop),
  .at_trig  (at_trig)
);

// File: tb/tagq_rx_fifo_test.sv
`timescale 1ns/1ps
module tagq_rx_fifo_test;

  localparam int DEPTH = 64;
  localparam int DW    = 8;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0, wr_en = 1'b0, wr_eof = 1'b0, wr_crc_err = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] trig_sel = 2'b00;
  logic irq_en = 1'b0, ovr_clr = 1'b0;
  logic rd_valid, rd_eof, rd_crc_err, irq, dma_req, overrun, full;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] level;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [9:0] mq[$];
  bit m_ovr = 1'b0;

  always #2.5 clk = ~clk;

  tagq_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_en(wr_en), .wr_data(wr_data),
    .wr_eof(wr_eof), .wr_crc_err(wr_crc_err), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_eof(rd_eof), .rd_crc_err(rd_crc_err), .trig_sel(trig_sel),
    .irq_en(irq_en), .irq(irq), .dma_req(dma_req), .overrun(overrun),
    .ovr_clr(ovr_clr), .full(full), .level(level)
  );

  function automatic int thr_of(input logic [1:0] s);
    return (s == 2'b11) ? 32 : (8 << s);
  endfunction

  function automatic bit any_crc();
    foreach (mq[i]) if (mq[i][9]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int n;
    n = mq.size();
    check("R10 level", int'(level), n);
    check("R10 full", int'(full), int'(n == DEPTH));
    check("R2 valid", int'(rd_valid), int'(n != 0));
    if (n != 0) check("R2 head", int'({rd_crc_err, rd_eof, rd_data}), int'(mq[0]));
    check("R5 R6 irq", int'(irq), int'(irq_en && n >= thr_of(trig_sel)));
    check("R5 R7 dma", int'(dma_req), int'(n >= thr_of(trig_sel) && !any_crc()));
    check("R4 overrun", int'(overrun), int'(m_ovr));
  endtask

  task automatic step(input logic w, input logic [7:0] d, input logic e, input logic c,
                      input logic r, input logic cl, input logic oc);
    bit was_full;
    wr_en = w; wr_data = d; wr_eof = e; wr_crc_err = c;
    rd_en = r; clear = cl; ovr_clr = oc;
    @(posedge clk);
    if (cl) begin
      mq.delete();
      m_ovr = 1'b0;
    end else begin
      was_full = (mq.size() == DEPTH);
      if (r && mq.size() > 0) void'(mq.pop_front());
      if (w && !was_full) mq.push_back({c, e, d});
      if (w && was_full) m_ovr = 1'b1;
      else if (oc) m_ovr = 1'b0;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7315));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 level", int'(level), 0);
    check("R1 valid", int'(rd_valid), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 dma", int'(dma_req), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 full", int'(full), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: pop on empty
    step(0, 8'h00, 0, 0, 1, 0, 0);
    check("R9 level stays 0", int'(level), 0);

    // R5/R6: fill to full with irq enabled at threshold 8
    irq_en = 1'b1; trig_sel = 2'b00;
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 3 + 1), (i % 5) == 4, 0, 0, 0, 0);
    check("R10 full at depth", int'(full), 1);

    // R3/R4: write while full is dropped, overrun set
    step(1, 8'hEE, 1, 1, 0, 0, 0);
    check("R3 level unchanged", int'(level), DEPTH);
    check("R4 overrun set", int'(overrun), 1);
    // R4: dropped write and clear together, set wins
    step(1, 8'hDD, 0, 0, 0, 0, 1);
    check("R4 set wins over clear", int'(overrun), 1);
    // R3: write and pop while full: pop happens, write dropped
    step(1, 8'hCC, 0, 0, 1, 0, 0);
    check("R3 pop while full", int'(level), DEPTH - 1);
    step(0, 8'h00, 0, 0, 0, 0, 1);
    check("R4 cleared", int'(overrun), 0);

    // R2: drain and compare order
    while (mq.size() > 0) step(0, 8'h00, 0, 0, 1, 0, 0);

    // R7: checksum-tagged entry blocks dma until it is popped
    trig_sel = 2'b01;
    step(1, 8'h5A, 1, 1, 0, 0, 0);
    for (int i = 0; i < 20; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    check("R7 dma held by tag", int'(dma_req), 0);
    step(0, 8'h00, 0, 0, 1, 0, 0);
    check("R7 dma resumes", int'(dma_req), 1);

    // R8: clear with simultaneous write and pop
    step(1, 8'h77, 0, 0, 1, 1, 0);
    check("R8 emptied", int'(level), 0);

    // R5: threshold 32 through code 2'b11
    trig_sel = 2'b11;
    for (int i = 0; i < 31; i++) step(1, 8'(i), 0, 0, 0, 0, 0);
    check("R5 below 32", int'(irq), 0);
    step(1, 8'h20, 0, 0, 0, 0, 0);
    check("R5 at 32", int'(irq), 1);
    step(0, 8'h00, 0, 0, 0, 1, 0);

    // random traffic
    for (int k = 0; k < 6000; k++) begin
      bit wh;
      int pw, pr;
      wh = ((k / 300) % 2) == 0;
      pw = wh ? 80 : 30;
      pr = wh ? 25 : 75;
      if (k % 200 == 0) trig_sel = 2'($urandom_range(0, 3));
      if (k % 100 == 0) irq_en = 1'($urandom_range(0, 1));
      step(($urandom_range(0, 99) < pw), 8'($urandom), ($urandom_range(0, 7) == 0),
           ($urandom_range(0, 15) == 0), ($urandom_range(0, 99) < pr),
           ($urandom_range(0, 999) == 0), ($urandom_range(0, 49) == 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule